// File: doc/BRIEF.md
# Snoop Ordering Resolver for a Miss Entry

This block sits beside one outstanding miss entry of a cache and decides, for a coherence snoop that hits the same block, how the snoop and the entry's own request are ordered. It takes the snoop's command code and flags, together with the entry's state bits. It then chooses one of three outcomes. The snoop may be ignored as logically older than the miss. It may be captured as a snoop-sourced target and replayed after the fill. Or it may leave behind an invalidate or downgrade to be applied once the fill returns.

The owner of the entry presents a one-cycle `snp_valid` pulse along with the snoop fields and the entry state. One clock edge later, the block returns a registered verdict. The verdict carries a handled flag, markings to apply to the snoop, a request to enqueue a captured target together with that target's pending and will-respond attributes, upgrade-rewrite strobes for the primary and deferred target queues, and set strobes for the post-invalidate and post-downgrade state. The block keeps no targets and has no response path of its own.

Top module: `snp_order_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0.
- R2: Every output is registered. It reflects the inputs sampled on the clock edge where `snp_valid` was 1, and `res_valid` is 1 only in that following cycle. After an edge where `snp_valid` was 0, all outputs are 0.
- R3: When the entry is not in service, or when the snoop is express and the entry is downstream-pending, the snoop precedes the miss. In that case `res_handled` is 0, `rw_prim` and `rw_defer` both equal `snp_needs_wr`, and every capture, marking and set strobe is 0.
- R4: When the miss precedes the snoop, `res_handled` is 1, `rw_defer` equals `snp_needs_wr`, and `rw_prim` is 0.
- R5: When the miss precedes the snoop and post-invalidate is already set, nothing beyond R4 and R11 happens. Capture, marking and set strobes are all 0.
- R6: Otherwise, the snoop is captured (`cap_req`) when the entry is pending-modified or the snoop is an invalidation. The captured target's `cap_pending` equals downstream-pending AND primary-needs-writable.
- R7: `cap_respond` is 1 only for a captured snoop when the entry is pending-modified, the snoop needs a response, and `snp_cmd` is not the plain-invalidate code (parameter `INVAL_CMD`, default 4'd6).
- R8: On the capture path, if the entry is pending-modified, both `mark_resp` and `mark_had_wr` are 1.
- R9: A captured snoop that needs a writable copy raises `set_post_inval`.
- R10: On the path of R6, a snoop that does not need a writable copy and is cacheable raises both `set_post_down` and `mark_sharers`.
- R11: `snp_illegal` is 1 for every valid snoop whose needs-writable flag differs from its is-invalidate flag, on every ordering path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| snp_valid | input | 1 | One-cycle snoop strobe |
| snp_cmd | input | CMD_W | Snoop command code |
| snp_needs_wr | input | 1 | Snoop wants a writable copy |
| snp_is_inval | input | 1 | Snoop invalidates other copies |
| snp_needs_resp | input | 1 | Snoop expects a response |
| snp_express | input | 1 | Snoop is an express snoop |
| snp_uncache | input | 1 | Snoop is uncacheable |
| ent_in_service | input | 1 | Entry's request has been issued |
| ent_dn_pending | input | 1 | Entry's request is buffered downstream |
| ent_pend_mod | input | 1 | Entry awaits a writable copy |
| ent_post_inval | input | 1 | Post-fill invalidate already scheduled |
| ent_prim_needs_wr | input | 1 | Primary queue needs a writable copy |
| res_valid | output | 1 | Verdict valid |
| res_handled | output | 1 | Snoop handled by the entry |
| rw_prim | output | 1 | Rewrite upgrades on the primary queue |
| rw_defer | output | 1 | Rewrite upgrades on the deferred queue |
| cap_req | output | 1 | Enqueue snoop-sourced target |
| cap_pending | output | 1 | Pending mark of the captured target |
| cap_respond | output | 1 | Entry will respond to the captured snoop |
| mark_resp | output | 1 | Mark snoop cache-responding |
| mark_had_wr | output | 1 | Mark snoop responder-had-writable |
| mark_sharers | output | 1 | Mark snoop has-sharers |
| set_post_inval | output | 1 | Set post-invalidate |
| set_post_down | output | 1 | Set post-downgrade |
| snp_illegal | output | 1 | Inconsistent snoop flags |

## Verification
The hardest case to reach is the express-snoop override. Here the entry is in service, yet an express snoop still counts as older than the miss because the entry is downstream-pending, and it must take the precede path even when pending-modified and post-invalidate are also set. The stimulus sweeps every combination of the eleven flag and state bits and of two command codes, with idle cycles between them. This reaches that override and every other path, including the inconsistent-flag combinations. A behavioural model in the bench predicts each output for the following cycle.

// File: rtl/snp_order_pkg.sv
package snp_order_pkg;

   typedef struct packed {
      logic handled;
      logic rw_prim;
      logic rw_defer;
      logic cap_req;
      logic cap_pending;
      logic cap_respond;
      logic mark_resp;
      logic mark_had_wr;
      logic mark_sharers;
      logic set_pinv;
      logic set_pdown;
      logic illegal;
   } snp_verdict_t;

   localparam int VERDICT_W = $bits(snp_verdict_t);

endpackage

// File: rtl/snp_precede_unit.sv
module snp_precede_unit (
   input  logic in_service,
   input  logic dn_pending,
   input  logic express,
   input  logic needs_wr,
   output logic follows,
   output logic rw_prim,
   output logic rw_defer
);
   logic precedes;

   // an unissued miss, or one still parked below us on an express path, is younger
   assign precedes = ~in_service | (express & dn_pending);
   assign follows  = ~precedes;
   assign rw_prim  = precedes & needs_wr;
   assign rw_defer = needs_wr;
endmodule

// File: rtl/snp_capture_unit.sv
module snp_capture_unit #(
   parameter int              CMD_W     = 4,
   parameter logic [CMD_W-1:0] INVAL_CMD = 4'd6
) (
   input  logic             active,
   input  logic             pend_mod,
   input  logic             is_inval,
   input  logic             needs_wr,
   input  logic             needs_resp,
   input  logic             dn_pending,
   input  logic             prim_needs_wr,
   input  logic [CMD_W-1:0] cmd,
   output logic             cap_req,
   output logic             cap_pending,
   output logic             cap_respond,
   output logic             mark_resp,
   output logic             mark_had_wr,
   output logic             set_pinv
);
   logic plain_inval;

   assign plain_inval = (cmd == INVAL_CMD);
   assign cap_req     = active & (pend_mod | is_inval);
   assign cap_pending = cap_req & dn_pending & prim_needs_wr;
   assign cap_respond = cap_req & pend_mod & needs_resp & ~plain_inval;
   // ordering point: responds, and tells the hierarchy it held the line writable
   assign mark_resp   = cap_req & pend_mod;
   assign mark_had_wr = cap_req & pend_mod;
   assign set_pinv    = cap_req & needs_wr;
endmodule

// File: rtl/snp_share_unit.sv
module snp_share_unit (
   input  logic active,
   input  logic needs_wr,
   input  logic uncache,
   output logic set_pdown,
   output logic mark_sharers
);
   logic shared_read;

   assign shared_read  = active & ~needs_wr & ~uncache;
   assign set_pdown    = shared_read;
   assign mark_sharers = shared_read;
endmodule

// File: rtl/snp_order_resolver.sv
module snp_order_resolver
   import snp_order_pkg::*;
#(
   parameter int               CMD_W     = 4,
   parameter logic [CMD_W-1:0] INVAL_CMD = 4'd6,
   parameter bit               OUT_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snp_valid,
   input  logic [CMD_W-1:0] snp_cmd,
   input  logic             snp_needs_wr,
   input  logic             snp_is_inval,
   input  logic             snp_needs_resp,
   input  logic             snp_express,
   input  logic             snp_uncache,
   input  logic             ent_in_service,
   input  logic             ent_dn_pending,
   input  logic             ent_pend_mod,
   input  logic             ent_post_inval,
   input  logic             ent_prim_needs_wr,
   output logic             res_valid,
   output logic             res_handled,
   output logic             rw_prim,
   output logic             rw_defer,
   output logic             cap_req,
   output logic             cap_pending,
   output logic             cap_respond,
   output logic             mark_resp,
   output logic             mark_had_wr,
   output logic             mark_sharers,
   output logic             set_post_inval,
   output logic             set_post_down,
   output logic             snp_illegal
);

   if (CMD_W < 1) begin : g_bad_cmd_w
      $error("snp_order_resolver: CMD_W must be at least 1");
   end

   logic         follows;
   logic         active;
   snp_verdict_t v_comb;
   snp_verdict_t v_gated;
   snp_verdict_t v_out;
   logic         valid_out;

   snp_precede_unit u_precede (
      .in_service (ent_in_service),
      .dn_pending (ent_dn_pending),
      .express    (snp_express),
      .needs_wr   (snp_needs_wr),
      .follows    (follows),
      .rw_prim    (v_comb.rw_prim),
      .rw_defer   (v_comb.rw_defer)
   );

   // an earlier invalidating snoop already took the block away
   assign active = follows & ~ent_post_inval;

   snp_capture_unit #(
      .CMD_W     (CMD_W),
      .INVAL_CMD (INVAL_CMD)
   ) u_capture (
      .active        (active),
      .pend_mod      (ent_pend_mod),
      .is_inval      (snp_is_inval),
      .needs_wr      (snp_needs_wr),
      .needs_resp    (snp_needs_resp),
      .dn_pending    (ent_dn_pending),
      .prim_needs_wr (ent_prim_needs_wr),
      .cmd           (snp_cmd),
      .cap_req       (v_comb.cap_req),
      .cap_pending   (v_comb.cap_pending),
      .cap_respond   (v_comb.cap_respond),
      .mark_resp     (v_comb.mark_resp),
      .mark_had_wr   (v_comb.mark_had_wr),
      .set_pinv      (v_comb.set_pinv)
   );

   snp_share_unit u_share (
      .active       (active),
      .needs_wr     (snp_needs_wr),
      .uncache      (snp_uncache),
      .set_pdown    (v_comb.set_pdown),
      .mark_sharers (v_comb.mark_sharers)
   );

   assign v_comb.handled = follows;
   assign v_comb.illegal = snp_needs_wr ^ snp_is_inval;
   assign v_gated        = snp_valid ? v_comb : '0;

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_out     <= '0;
            valid_out <= 1'b0;
         end else begin
            v_out     <= v_gated;
            valid_out <= snp_valid;
         end
      end
   end else begin : g_comb_out
      assign v_out     = v_gated;
      assign valid_out = snp_valid;
   end

   assign res_valid      = valid_out;
   assign res_handled    = v_out.handled;
   assign rw_prim        = v_out.rw_prim;
   assign rw_defer       = v_out.rw_defer;
   assign cap_req        = v_out.cap_req;
   assign cap_pending    = v_out.cap_pending;
   assign cap_respond    = v_out.cap_respond;
   assign mark_resp      = v_out.mark_resp;
   assign mark_had_wr    = v_out.mark_had_wr;
   assign mark_sharers   = v_out.mark_sharers;
   assign set_post_inval = v_out.set_pinv;
   assign set_post_down  = v_out.set_pdown;
   assign snp_illegal    = v_out.illegal;

endmodule

// File: rtl/snp_order_checker.sv
module snp_order_checker #(
   parameter bit OUT_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic snp_valid,
   input logic snp_needs_wr,
   input logic snp_is_inval,
   input logic snp_express,
   input logic ent_in_service,
   input logic ent_dn_pending,
   input logic ent_post_inval,
   input logic res_valid,
   input logic res_handled,
   input logic rw_prim,
   input logic rw_defer,
   input logic cap_req,
   input logic cap_respond,
   input logic mark_resp,
   input logic mark_had_wr,
   input logic mark_sharers,
   input logic set_post_inval,
   input logic set_post_down,
   input logic snp_illegal
);
   logic [11:0] strobes;
   assign strobes = {res_handled, rw_prim, rw_defer, cap_req, cap_respond, mark_resp,
                     mark_had_wr, mark_sharers, set_post_inval, set_post_down, snp_illegal, 1'b0};

   if (OUT_REG) begin : g_timed
      p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
         snp_valid |=> res_valid);
      p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !snp_valid |=> (!res_valid && $countones(strobes) == 0));
      p_precede_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && $past(!ent_in_service || (snp_express && ent_dn_pending)))
         |-> (!res_handled && !cap_req && !mark_resp && !set_post_inval && !set_post_down
              && rw_prim == rw_defer));
      p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && $past(ent_in_service && !(snp_express && ent_dn_pending)))
         |-> (res_handled && !rw_prim && rw_defer == $past(snp_needs_wr)));
      p_postinv_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && res_handled && $past(ent_post_inval))
         |-> (!cap_req && !mark_sharers && !set_post_inval && !set_post_down));
      p_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid |-> (snp_illegal == $past(snp_needs_wr ^ snp_is_inval)));
   end

   p_respond_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_respond |-> cap_req);
   p_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_resp || mark_had_wr) |-> (cap_req && res_handled));
   p_pinv_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_post_inval |-> (cap_req && res_handled));
   p_down_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_post_down |-> (!set_post_inval && res_handled));
endmodule

bind snp_order_resolver snp_order_checker #(.OUT_REG(OUT_REG)) u_order_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .snp_valid      (snp_valid),
   .snp_needs_wr   (snp_needs_wr),
   .snp_is_inval   (snp_is_inval),
   .snp_express    (snp_express),
   .ent_in_service (ent_in_service),
   .ent_dn_pending (ent_dn_pending),
   .ent_post_inval (ent_post_inval),
   .res_valid      (res_valid),
   .res_handled    (res_handled),
   .rw_prim        (rw_prim),
   .rw_defer       (rw_defer),
   .cap_req        (cap_req),
   .cap_respond    (cap_respond),
   .mark_resp      (mark_resp),
   .mark_had_wr    (mark_had_wr),
   .mark_sharers   (mark_sharers),
   .set_post_inval (set_post_inval),
   .set_post_down  (set_post_down),
   .snp_illegal    (snp_illegal)
);

// File: tb/test_snp_order_resolver.sv
`timescale 1ns/1ps
module test_snp_order_resolver;
   localparam logic [3:0] INV_CODE   = 4'd6;
   localparam logic [3:0] OTHER_CODE = 4'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       snp_valid, snp_needs_wr, snp_is_inval, snp_needs_resp, snp_express, snp_uncache;
   logic [3:0] snp_cmd;
   logic       ent_in_service, ent_dn_pending, ent_pend_mod, ent_post_inval, ent_prim_needs_wr;
   logic res_valid, res_handled, rw_prim, rw_defer, cap_req, cap_pending, cap_respond;
   logic mark_resp, mark_had_wr, mark_sharers, set_post_inval, set_post_down, snp_illegal;

   snp_order_resolver i_snp_order_resolver (.*);

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   // expected values for the next cycle
   logic e_val, e_hdl, e_rwp, e_rwd, e_cap, e_cpd, e_rsp, e_mr, e_mh, e_sh, e_spi, e_spd, e_ill;
   bit   e_pinv_path;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model();
      {e_val, e_hdl, e_rwp, e_rwd, e_cap, e_cpd, e_rsp, e_mr, e_mh, e_sh, e_spi, e_spd, e_ill} = '0;
      e_pinv_path = 0;
      e_val = snp_valid;
      if (!snp_valid) return;
      e_ill = (snp_needs_wr != snp_is_inval);
      if (!ent_in_service || (snp_express && ent_dn_pending)) begin
         e_rwp = snp_needs_wr;
         e_rwd = snp_needs_wr;
         return;
      end
      e_hdl = 1;
      e_rwd = snp_needs_wr;
      if (ent_post_inval) begin
         e_pinv_path = 1;
         return;
      end
      if (ent_pend_mod || snp_is_inval) begin
         e_cap = 1;
         e_cpd = ent_dn_pending && ent_prim_needs_wr;
         e_rsp = ent_pend_mod && snp_needs_resp && (snp_cmd != INV_CODE);
         if (ent_pend_mod) begin
            e_mr = 1;
            e_mh = 1;
         end
         if (snp_needs_wr) e_spi = 1;
      end
      if (!snp_needs_wr && !snp_uncache) begin
         e_spd = 1;
         e_sh  = 1;
      end
   endtask

   task automatic compare();
      chk("R2 res_valid", res_valid, e_val);
      chk("R3 res_handled", res_handled, e_hdl);
      chk("R3 rw_prim", rw_prim, e_rwp);
      chk("R4 rw_defer", rw_defer, e_rwd);
      chk("R6 cap_req", cap_req, e_cap);
      chk("R6 cap_pending", cap_pending, e_cpd);
      chk("R7 cap_respond", cap_respond, e_rsp);
      chk("R8 mark_resp", mark_resp, e_mr);
      chk("R8 mark_had_wr", mark_had_wr, e_mh);
      chk("R9 set_post_inval", set_post_inval, e_spi);
      chk("R10 set_post_down", set_post_down, e_spd);
      chk("R10 mark_sharers", mark_sharers, e_sh);
      chk("R11 snp_illegal", snp_illegal, e_ill);
      if (e_pinv_path)
         chk("R5 no action after post-invalidate",
             cap_req | mark_resp | set_post_inval | set_post_down | mark_sharers, 1'b0);
   endtask

   task automatic drive(input int code);
      snp_valid         = code[0];
      snp_needs_wr      = code[1];
      snp_is_inval      = code[2];
      snp_needs_resp    = code[3];
      snp_express       = code[4];
      snp_uncache       = code[5];
      ent_in_service    = code[6];
      ent_dn_pending    = code[7];
      ent_pend_mod      = code[8];
      ent_post_inval    = code[9];
      ent_prim_needs_wr = code[10];
      snp_cmd           = code[11] ? INV_CODE : OTHER_CODE;
   endtask

   initial begin
      drive(0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet under reset
      chk("R1 reset outputs", |{res_valid, res_handled, rw_prim, rw_defer, cap_req, cap_pending,
          cap_respond, mark_resp, mark_had_wr, mark_sharers, set_post_inval, set_post_down,
          snp_illegal}, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first cycle after reset", res_valid, 1'b0);
      for (int i = 0; i < 4096; i++) begin
         drive(i);
         model();
         @(negedge clk);
         compare();
      end
      drive(0);
      model();
      @(negedge clk);
      compare();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog expired: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule